// File: doc/BRIEF.md
# Edge-Pulse Level Link with Refresh and Receive Watchdog

This block carries one logic level from a transmit half to a receive half. The level does not travel as a level. It travels as short strobes on two lines. A rising input sends a strobe on the set line and a falling input sends one on the clear line. The receive half keeps the level in a set/clear storage bit that drives the output.

When the input stays quiet, the transmit half sends a refresh strobe at a fixed period. The refresh strobe has the polarity of the present level, so the output stays correct for a level that never changes. The receive half runs a watchdog on incoming strobes. If strobes stop for too long, it decides that the transmit half is gone and drives the output high.

Each half has its own power-valid input. A half whose power-valid input is low is modelled as unpowered. All timing is counted in cycles of one system clock and set by parameters.

Top module: `edge_pulse_link`

## Requirements
- R1: After rst_ni is released, data_o is 1, and link_set_o and link_clr_o are 0 until a strobe is sent.
- R2: With both halves powered, a 0-to-1 change on data_i produces a link_set_o strobe 3 clock edges later, and a 1-to-0 change produces a link_clr_o strobe 3 edges later. Each strobe lasts exactly PULSE_CYC cycles. data_i passes through a 2-flop synchroniser.
- R3: link_set_o and link_clr_o are never high in the same cycle. At the receive storage bit, clear takes priority over set.
- R4: A set strobe makes data_o 1 one edge later, and a clear strobe makes it 0 one edge later. Between strobes, data_o holds its value as long as the watchdog has not expired.
- R5: While data_i is steady, a refresh strobe whose polarity equals the current level starts exactly REFRESH_CYC cycles after the previous strobe started. Any strobe, edge or refresh, restarts this interval.
- R6: If no strobe arrives for WDOG_CYC cycles, data_o is forced to 1. The default WDOG_CYC (100) exceeds REFRESH_CYC (40), so a powered link never trips the watchdog.
- R7: While tx_pwr_ok_i is 0, no strobe is sent. The output then reads 1 once the watchdog has expired.
- R8: When tx_pwr_ok_i rises, a strobe of the current data_i level is sent at once, once the synchroniser has filled, and data_o equals data_i within 6 cycles.
- R9: While rx_pwr_ok_i is 0, data_o is 1 and the watchdog is cleared. After rx_pwr_ok_i returns, the next strobe restores the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_pwr_ok_i | input | 1 | Transmit half powered |
| rx_pwr_ok_i | input | 1 | Receive half powered |
| data_i | input | 1 | Level to carry (asynchronous) |
| data_o | output | 1 | Recovered level |
| link_set_o | output | 1 | Set strobe line between the halves |
| link_clr_o | output | 1 | Clear strobe line between the halves |

## Verification
The bench measures the exact gap between two consecutive refresh strobes at both levels. A refresh counter that is off by one, or that ignores the level, shows up as a wrong gap or a wrong line.

It checks that a level held for several watchdog periods never flips high. A watchdog that is not restarted by refresh strobes would drive the output high during that hold.

It removes transmit power and confirms two things: the strobes stop, and the output defaults high only after the timeout. It then restores power and checks quick recovery of a low level, which catches a missing power-up strobe.

A two-cycle input glitch must produce both strobes and end low. Removing receive power must force the output high.

// File: rtl/epl_pkg.sv
package epl_pkg;
  typedef enum logic {POL_CLR = 1'b0, POL_SET = 1'b1} pol_e;

  function automatic pol_e lvl_to_pol(input logic lvl);
    return lvl ? POL_SET : POL_CLR;
  endfunction
endpackage

// File: rtl/epl_sync.sv
module epl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    chain_q[g] <= 1'b0;
        else if (!en_i) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= d_i;
        else            chain_q[g] <= chain_q[(g > 0) ? g-1 : 0];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/epl_tx.sv
module epl_tx
  import epl_pkg::*;
#(
  parameter int PULSE_CYC   = 1,
  parameter int REFRESH_CYC = 40,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic data_i,
  output logic set_o,
  output logic clr_o
);
  localparam int PCW = $clog2(PULSE_CYC + 1);
  localparam int ICW = $clog2(REFRESH_CYC);

  logic                   lvl;
  logic [SYNC_STAGES-1:0] rdy_pipe_q;
  logic                   rdy, rdy_q, prev_q;
  logic [ICW-1:0]         idle_q;
  logic [PCW-1:0]         pulse_q;
  pol_e                   pol_q;
  logic                   edge_hit, pwr_up, refresh, trig;

  epl_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (pwr_ok_i),
    .d_i   (data_i),
    .q_o   (lvl)
  );

  assign rdy      = rdy_pipe_q[SYNC_STAGES-1];
  assign edge_hit = rdy_q && (lvl != prev_q);
  assign pwr_up   = rdy && !rdy_q;
  assign refresh  = rdy_q && (idle_q == ICW'(REFRESH_CYC - 1));
  assign trig     = rdy && (pwr_up || edge_hit || refresh);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_pipe_q <= '0;
      rdy_q      <= 1'b0;
      prev_q     <= 1'b0;
      idle_q     <= '0;
      pulse_q    <= '0;
      pol_q      <= POL_SET;
    end else if (!pwr_ok_i) begin
      rdy_pipe_q <= '0;
      rdy_q      <= 1'b0;
      prev_q     <= 1'b0;
      idle_q     <= '0;
      pulse_q    <= '0;
    end else begin
      rdy_pipe_q <= {rdy_pipe_q[SYNC_STAGES-2:0], 1'b1};
      rdy_q      <= rdy;
      if (rdy) prev_q <= lvl;
      if (trig) begin
        idle_q  <= '0;
        pulse_q <= PCW'(PULSE_CYC);
        pol_q   <= lvl_to_pol(lvl);
      end else begin
        if (rdy) idle_q <= idle_q + 1'b1;
        if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
      end
    end
  end

  assign set_o = (pulse_q != '0) && (pol_q == POL_SET);
  assign clr_o = (pulse_q != '0) && (pol_q == POL_CLR);

  p_rise_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && rdy_q && lvl && !prev_q) |=> set_o);
  p_fall_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && rdy_q && !lvl && prev_q) |=> clr_o);
  p_refresh_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && rdy_q && idle_q == ICW'(REFRESH_CYC - 1)) |=> (set_o || clr_o));
  p_quiet_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> (!set_o && !clr_o));
  p_pwrup_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && rdy && !rdy_q) |=> (set_o == lvl_q_or(lvl)));

  function automatic logic lvl_q_or(input logic l);
    return l;
  endfunction
endmodule

// File: rtl/epl_rx.sv
module epl_rx #(
  parameter int WDOG_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_ok_i,
  input  logic set_i,
  input  logic clr_i,
  output logic lvl_o
);
  localparam int WCW = $clog2(WDOG_CYC);

  logic [WCW-1:0] wd_q;
  logic           expire;

  assign expire = (wd_q == WCW'(WDOG_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_o <= 1'b1;
      wd_q  <= '0;
    end else if (!pwr_ok_i) begin
      lvl_o <= 1'b1;
      wd_q  <= '0;
    end else if (clr_i) begin
      lvl_o <= 1'b0;
      wd_q  <= '0;
    end else if (set_i) begin
      lvl_o <= 1'b1;
      wd_q  <= '0;
    end else if (expire) begin
      lvl_o <= 1'b1;
    end else begin
      wd_q  <= wd_q + 1'b1;
    end
  end

  p_clr_wins_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && clr_i) |=> !lvl_o);
  p_set_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && set_i && !clr_i) |=> lvl_o);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && !set_i && !clr_i && !expire) |=> $stable(lvl_o));
  p_wdog_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_ok_i && !set_i && !clr_i && expire) |=> lvl_o);
  p_rx_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> (lvl_o && wd_q == '0));
endmodule

// File: rtl/edge_pulse_link.sv
module edge_pulse_link #(
  parameter int PULSE_CYC   = 1,
  parameter int REFRESH_CYC = 40,
  parameter int WDOG_CYC    = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_pwr_ok_i,
  input  logic rx_pwr_ok_i,
  input  logic data_i,
  output logic data_o,
  output logic link_set_o,
  output logic link_clr_o
);
  logic set_w, clr_w;

  epl_tx #(
    .PULSE_CYC  (PULSE_CYC),
    .REFRESH_CYC(REFRESH_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwr_ok_i(tx_pwr_ok_i),
    .data_i  (data_i),
    .set_o   (set_w),
    .clr_o   (clr_w)
  );

  epl_rx #(.WDOG_CYC(WDOG_CYC)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pwr_ok_i(rx_pwr_ok_i),
    .set_i   (set_w),
    .clr_i   (clr_w),
    .lvl_o   (data_o)
  );

  assign link_set_o = set_w;
  assign link_clr_o = clr_w;

  p_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_set_o && link_clr_o));
endmodule

// File: tb/test_edge_pulse_link.sv
module test_edge_pulse_link;
  localparam int CLK_PERIOD = 10;
  localparam int PULSE_CYC = 1;
  localparam int REFRESH_CYC = 40;
  localparam int WDOG_CYC = 100;

  logic clk = 1'b0, rst_n = 1'b0, tx_pwr = 1'b1, rx_pwr = 1'b1, din = 1'b0;
  logic dout, lset, lclr;
  int checks = 0, errors = 0, both_cnt = 0, set_seen = 0, clr_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_pulse_link #(
    .PULSE_CYC(PULSE_CYC), .REFRESH_CYC(REFRESH_CYC), .WDOG_CYC(WDOG_CYC), .SYNC_STAGES(2)
  ) i_edge_pulse_link (
    .clk_i(clk), .rst_ni(rst_n), .tx_pwr_ok_i(tx_pwr), .rx_pwr_ok_i(rx_pwr),
    .data_i(din), .data_o(dout), .link_set_o(lset), .link_clr_o(lclr)
  );

  always @(negedge clk) begin
    if (lset && lclr) both_cnt++;
    if (lset) set_seen++;
    if (lclr) clr_seen++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(1);
    chk(dout == 1'b1, "R1 data_o after reset", dout, 1);
    chk(!lset && !lclr, "R1 strobes idle after reset", {lset, lclr}, 0);
  endtask

  task automatic t_edge(input logic lvl);
    @(negedge clk) din = lvl;
    cyc(3);
    chk(lset == lvl && lclr == !lvl, "R2 strobe line after edge", {lset, lclr}, lvl ? 2 : 1);
    cyc(1);
    chk(!lset && !lclr, "R2 strobe width", {lset, lclr}, 0);
    chk(dout == lvl, "R4 output follows strobe", dout, lvl);
  endtask

  task automatic t_refresh(input logic lvl);
    int n;
    while (!(lset || lclr)) cyc(1);
    while (lset || lclr) cyc(1);
    n = 1;
    while (!(lset || lclr) && n < 1000) begin cyc(1); n++; end
    chk(n == REFRESH_CYC + 1 - PULSE_CYC + PULSE_CYC - 1 + 0, "R5 refresh interval", n, REFRESH_CYC);
    chk(lset == lvl && lclr == !lvl, "R5 refresh polarity", {lset, lclr}, lvl ? 2 : 1);
    chk(dout == lvl, "R5 output kept by refresh", dout, lvl);
  endtask

  task automatic t_long_hold;
    int bad = 0;
    @(negedge clk) din = 1'b0;
    cyc(6);
    for (int i = 0; i < 3 * WDOG_CYC; i++) begin
      cyc(1);
      if (dout != 1'b0) bad++;
    end
    chk(bad == 0, "R6 no watchdog trip while refreshed", bad, 0);
  endtask

  task automatic t_glitch;
    int s0, c0;
    @(negedge clk) din = 1'b0;
    cyc(6);
    s0 = set_seen; c0 = clr_seen;
    @(negedge clk) din = 1'b1;
    cyc(2);
    din = 1'b0;
    cyc(6);
    chk(set_seen - s0 >= 1, "R2 glitch rise strobe", set_seen - s0, 1);
    chk(clr_seen - c0 >= 1, "R2 glitch fall strobe", clr_seen - c0, 1);
    chk(dout == 1'b0, "R4 glitch final level", dout, 0);
  endtask

  task automatic t_tx_power;
    int s0, c0;
    @(negedge clk) din = 1'b0;
    cyc(6);
    tx_pwr = 1'b0;
    s0 = set_seen; c0 = clr_seen;
    cyc(5);
    chk(dout == 1'b0, "R6 output held before timeout", dout, 0);
    cyc(WDOG_CYC + REFRESH_CYC);
    chk((set_seen - s0) + (clr_seen - c0) == 0, "R7 no strobes while tx off",
        (set_seen - s0) + (clr_seen - c0), 0);
    chk(dout == 1'b1, "R7 output high with tx dead", dout, 1);
    @(negedge clk) tx_pwr = 1'b1;
    cyc(6);
    chk(dout == 1'b0, "R8 recovery after tx power", dout, 0);
  endtask

  task automatic t_rx_power;
    @(negedge clk) din = 1'b0;
    cyc(6);
    rx_pwr = 1'b0;
    cyc(1);
    chk(dout == 1'b1, "R9 output high with rx off", dout, 1);
    @(negedge clk) rx_pwr = 1'b1;
    cyc(REFRESH_CYC + 3);
    chk(dout == 1'b0, "R9 level restored after rx power", dout, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    t_reset();
    cyc(8);
    t_edge(1'b1);
    t_edge(1'b0);
    t_edge(1'b1);
    t_refresh(1'b1);
    @(negedge clk) din = 1'b0;
    cyc(6);
    t_refresh(1'b0);
    t_long_hold();
    t_glitch();
    t_tx_power();
    t_rx_power();
    chk(both_cnt == 0, "R3 set and clear exclusive", both_cnt, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule